// File: doc/BRIEF.md
# Write-Miss Allocation Controller

This block is the store path of a small set-associative data cache. It accepts one CPU access at a time, looks it up in a tag store with valid and dirty flags, and either completes it at once or runs a short sequence on the external memory bus. One mode input selects the policy: in write-back mode a store miss allocates a line, and in write-through mode every store is also sent out to memory and a store miss leaves the cache untouched.

On a write-back store miss the controller chooses a victim way. The victim is the lowest-numbered invalid way, or else the least recently used way. If the victim holds modified data, the whole line and its address are handed to an external eviction buffer first, so the refill does not have to wait for the write-back. The line is then fetched as a burst of four longwords, the store bytes are merged in, and the line becomes valid, dirty and most recently used. Loads that hit return their longword one cycle later; load misses are only reported and allocate nothing. A busy output holds the CPU off while a bus sequence is in progress.

Top module: `wmiss_alloc_ctrl`

## Requirements
- R1: After reset, busy, mem_req and evb_push are low and every cache line is invalid, so any load reports a miss.
- R2: A write-back store that hits writes only the enabled bytes (cpu_be bit k selects byte k, bits 8k+7:8k) of the addressed longword, marks the line dirty, and raises neither busy nor mem_req.
- R3: On a write-back store miss the victim is the lowest-numbered invalid way of the set; if all ways are valid it is the least recently used way.
- R4: A victim that is valid and dirty is pushed once to the eviction buffer before the first refill request. evb_addr is {tag, set}, evb_data carries longword n in bits 32n+31:32n. The push waits while evb_full is high and no refill request is made meanwhile.
- R5: The refill issues four reads with mem_we low at word addresses {tag, set, 0} through {tag, set, 3} in that order. Each request and its address stay steady until mem_ack.
- R6: After the fourth refill beat the line holds the fetched longwords with the store bytes merged into the addressed longword, and it is valid and dirty.
- R7: Any load hit, store hit or refill makes the accessed way the most recently used in its set.
- R8: A write-through store miss changes no line and issues one write with mem_we high, mem_addr equal to the store word address, and the store data and byte enables.
- R9: A write-through store hit merges the store into the line, leaves its dirty flag unchanged, and issues one external write as in R8.
- R10: busy rises only in the cycle after a store is accepted and stays high until the sequence ends; it goes low in the cycle after the line update or final write acknowledgement.
- R11: A load is answered one cycle after acceptance with rd_valid high, rd_hit showing the lookup result and, on a hit, rd_data holding the addressed longword; a load miss changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back policy, 0 = write-through |
| cpu_req | input | 1 | Access request, taken when busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_waddr | input | 30 | Word address: tag, set, longword offset |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| busy | output | 1 | Bus sequence in progress |
| rd_valid | output | 1 | Load answer valid |
| rd_hit | output | 1 | Load hit flag |
| rd_data | output | 32 | Load data |
| mem_req | output | 1 | External bus request |
| mem_we | output | 1 | External write (1) or read (0) |
| mem_addr | output | 30 | External word address |
| mem_wdata | output | 32 | External write data |
| mem_be | output | 4 | External byte enables |
| mem_ack | input | 1 | Bus acknowledge for the current beat |
| mem_rdata | input | 32 | Refill read data |
| evb_full | input | 1 | Eviction buffer cannot accept a line |
| evb_push | output | 1 | Eviction buffer load strobe |
| evb_addr | output | 28 | Line address of the pushed victim |
| evb_data | output | 128 | Pushed victim line |

## Verification
Every cycle the assertions check that a bus request holds its address until acknowledged, that no refill starts while a dirty victim waits on a full eviction buffer, that a write-back hit stays off the bus, that busy only rises after an accepted store, that write-through cycles never touch the tag store, and that a touched way stops being least recently used. Victim choice, the pushed line contents, the merged bytes, the dirty flag surviving a write-through hit and the absence of allocation on a write-through miss are only visible across several operations, so the bench's reference model shows them through later loads and eviction pushes.

// File: rtl/wma_pkg.sv
package wma_pkg;

  localparam int WORD_W     = 32;
  localparam int LINE_WORDS = 4;
  localparam int OFF_W      = $clog2(LINE_WORDS);
  localparam int LINE_W     = WORD_W * LINE_WORDS;
  localparam int BE_W       = WORD_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_MERGE,
    ST_WT
  } wma_state_e;

  // Overwrite the enabled bytes of one longword inside a line.
  function automatic logic [LINE_W-1:0] merge_store(
    input logic [LINE_W-1:0] line,
    input logic [OFF_W-1:0]  off,
    input logic [WORD_W-1:0] data,
    input logic [BE_W-1:0]   be
  );
    logic [LINE_W-1:0] res;
    res = line;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) res[int'(off)*WORD_W + b*8 +: 8] = data[b*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/wma_tag_store.sv
module wma_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 24
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(SETS)-1:0]     lk_set,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_vec,
  output logic [WAYS-1:0]             vld_vec,
  output logic [WAYS-1:0]             dty_vec,
  input  logic                        wr_en,
  input  logic [$clog2(SETS)-1:0]     wr_set,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] wr_way,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_dty
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SETS-1:0][WAYS-1:0] vld_q, dty_q;
  logic [TAG_W-1:0]          tag_q [SETS][WAYS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic sel;
      assign sel = wr_en && (wr_set == SET_W'(s)) && (wr_way == WAY_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[s][w] <= 1'b0;
          dty_q[s][w] <= 1'b0;
        end else if (sel) begin
          vld_q[s][w] <= 1'b1;
          dty_q[s][w] <= wr_dty;
        end
      end

      always_ff @(posedge clk) begin
        if (sel) tag_q[s][w] <= wr_tag;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      tag_vec[w] = tag_q[lk_set][w];
      vld_vec[w] = vld_q[lk_set][w];
      dty_vec[w] = dty_q[lk_set][w];
    end
  end

endmodule

// File: rtl/wma_line_store.sv
module wma_line_store
  import wma_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                                 clk,
  input  logic [$clog2(SETS)-1:0]              rd_set,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] rd_way,
  output logic [LINE_W-1:0]                    rd_line,
  input  logic                                 wr_en,
  input  logic [$clog2(SETS)-1:0]              wr_set,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] wr_way,
  input  logic [LINE_W-1:0]                    wr_line
);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic [LINE_W-1:0] data_q [ENTRIES];
  logic [IDX_W-1:0]  rd_idx, wr_idx;

  assign rd_idx = IDX_W'(int'(rd_set) * WAYS + int'(rd_way));
  assign wr_idx = IDX_W'(int'(wr_set) * WAYS + int'(wr_way));

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx] <= wr_line;
  end

  assign rd_line = data_q[rd_idx];

endmodule

// File: rtl/wma_lru.sv
module wma_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [$clog2(SETS)-1:0]              rd_set,
  output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] lru_way,
  input  logic                                 touch_en,
  input  logic [$clog2(SETS)-1:0]              touch_set,
  input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] touch_way
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PAIRS = (WAYS > 1) ? WAYS * (WAYS - 1) / 2 : 1;

  // One bit per way pair (a<b): 1 means way a was used less recently than b.
  logic [SETS-1:0][PAIRS-1:0] age_q;

  function automatic logic [WAY_W-1:0] oldest_f(input logic [PAIRS-1:0] bits);
    logic older [WAYS][WAYS];
    logic all_older;
    logic [WAY_W-1:0] res;
    int idx;
    idx = 0;
    res = '0;
    for (int a = 0; a < WAYS; a++) older[a][a] = 1'b1;
    for (int a = 0; a < WAYS; a++) begin
      for (int b = a + 1; b < WAYS; b++) begin
        older[a][b] = bits[idx];
        older[b][a] = !bits[idx];
        idx++;
      end
    end
    for (int i = 0; i < WAYS; i++) begin
      all_older = 1'b1;
      for (int j = 0; j < WAYS; j++) begin
        if (!older[i][j]) all_older = 1'b0;
      end
      if (all_older) res = WAY_W'(i);
    end
    return res;
  endfunction

  function automatic logic [PAIRS-1:0] touch_f(input logic [PAIRS-1:0] bits,
                                               input logic [WAY_W-1:0] way);
    logic [PAIRS-1:0] res;
    int idx;
    res = bits;
    idx = 0;
    for (int a = 0; a < WAYS; a++) begin
      for (int b = a + 1; b < WAYS; b++) begin
        if (WAY_W'(a) == way) res[idx] = 1'b0;
        else if (WAY_W'(b) == way) res[idx] = 1'b1;
        idx++;
      end
    end
    return res;
  endfunction

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic upd;
    assign upd = touch_en && (touch_set == SET_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   age_q[s] <= '0;
      else if (upd) age_q[s] <= touch_f(age_q[s], touch_way);
    end
  end

  assign lru_way = oldest_f(age_q[rd_set]);

  // R7: a way that was just used is never the replacement choice next cycle.
  p_touch_not_lru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (WAYS < 2) || (oldest_f(age_q[$past(touch_set)]) != $past(touch_way)));

endmodule

// File: rtl/wmiss_alloc_ctrl.sv
module wmiss_alloc_ctrl
  import wma_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_mode,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [29:0]   cpu_waddr,
  input  logic [31:0]   cpu_wdata,
  input  logic [3:0]    cpu_be,
  output logic          busy,
  output logic          rd_valid,
  output logic          rd_hit,
  output logic [31:0]   rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [29:0]   mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          evb_full,
  output logic          evb_push,
  output logic [27:0]   evb_addr,
  output logic [127:0]  evb_data
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = 30 - OFF_W - SET_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_WORDS - 1);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wma_state_e st_q, st_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic [29:0]       q_waddr;
  logic [31:0]       q_data;
  logic [3:0]        q_be;
  logic [WAY_W-1:0]  q_way;
  logic [LINE_WORDS-1:0][WORD_W-1:0] fill_q;
  logic              rd_valid_q, rd_hit_q;
  logic [31:0]       rd_data_q;

  logic              acc, idle;
  logic [29:0]       lk_waddr;
  logic [OFF_W-1:0]  lk_off;
  logic [SET_W-1:0]  lk_set, q_set;
  logic [TAG_W-1:0]  lk_tag, q_tag;
  logic [OFF_W-1:0]  q_off;
  logic [WAYS-1:0][TAG_W-1:0] tag_vec;
  logic [WAYS-1:0]   vld_vec, dty_vec, hit_vec;
  logic              hit;
  logic [WAY_W-1:0]  hit_way, victim, lru_way, acc_way;
  logic              victim_dirty;
  logic [LINE_W-1:0] rd_line, wr_line;
  logic              tag_we, tag_wr_dty, touch_en;
  logic [WAY_W-1:0]  wr_way, line_rd_way;
  logic [TAG_W-1:0]  tag_wr_tag;

  assign idle     = (st_q == ST_IDLE);
  assign acc      = cpu_req && idle;
  assign lk_waddr = idle ? cpu_waddr : q_waddr;
  assign lk_off   = lk_waddr[OFF_W-1:0];
  assign lk_set   = lk_waddr[OFF_W +: SET_W];
  assign lk_tag   = lk_waddr[29 -: TAG_W];
  assign q_off    = q_waddr[OFF_W-1:0];
  assign q_set    = q_waddr[OFF_W +: SET_W];
  assign q_tag    = q_waddr[29 -: TAG_W];

  // Lookup and victim choice.
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = vld_vec[w] && (tag_vec[w] == lk_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    hit = |hit_vec;
  end

  always_comb begin
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld_vec[w]) victim = WAY_W'(w);
    end
    victim_dirty = vld_vec[victim] && dty_vec[victim];
  end

  assign acc_way = hit ? hit_way : victim;

  // Next-state logic.
  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    case (st_q)
      ST_IDLE: begin
        if (acc && cpu_we) begin
          if (!wb_mode)          st_d = ST_WT;
          else if (!hit)         st_d = victim_dirty ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: if (!evb_full) st_d = ST_FILL;
      ST_FILL: begin
        if (mem_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_d = ST_MERGE;
        end
      end
      ST_MERGE: st_d = ST_IDLE;
      ST_WT:    if (mem_ack) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
    end
  end

  // Request capture (enable: accepted access).
  always_ff @(posedge clk) begin
    if (acc) begin
      q_waddr <= cpu_waddr;
      q_data  <= cpu_wdata;
      q_be    <= cpu_be;
      q_way   <= acc_way;
    end
  end

  // Refill beat capture (enable: acknowledged fill beat).
  always_ff @(posedge clk) begin
    if (st_q == ST_FILL && mem_ack) fill_q[beat_q] <= mem_rdata;
  end

  // Array update control.
  assign tag_we      = (acc && cpu_we && hit) || (st_q == ST_MERGE);
  assign wr_way      = idle ? hit_way : q_way;
  assign tag_wr_tag  = idle ? lk_tag  : q_tag;
  assign tag_wr_dty  = idle ? (wb_mode || dty_vec[hit_way]) : 1'b1;
  assign touch_en    = (acc && hit) || (st_q == ST_MERGE);
  assign line_rd_way = idle ? hit_way : q_way;
  assign wr_line     = idle ? merge_store(rd_line, lk_off, cpu_wdata, cpu_be)
                            : merge_store(fill_q, q_off, q_data, q_be);

  wma_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n_s), .lk_set(lk_set),
    .tag_vec(tag_vec), .vld_vec(vld_vec), .dty_vec(dty_vec),
    .wr_en(tag_we), .wr_set(lk_set), .wr_way(wr_way),
    .wr_tag(tag_wr_tag), .wr_dty(tag_wr_dty)
  );

  wma_line_store #(.SETS(SETS), .WAYS(WAYS)) u_lines (
    .clk(clk), .rd_set(lk_set), .rd_way(line_rd_way), .rd_line(rd_line),
    .wr_en(tag_we), .wr_set(lk_set), .wr_way(wr_way), .wr_line(wr_line)
  );

  wma_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n_s), .rd_set(lk_set), .lru_way(lru_way),
    .touch_en(touch_en), .touch_set(lk_set), .touch_way(wr_way)
  );

  // Load answer.
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) rd_valid_q <= 1'b0;
    else          rd_valid_q <= acc && !cpu_we;
  end

  always_ff @(posedge clk) begin
    if (acc && !cpu_we) begin
      rd_hit_q  <= hit;
      rd_data_q <= hit ? rd_line[int'(lk_off)*WORD_W +: WORD_W] : '0;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_hit   = rd_hit_q;
  assign rd_data  = rd_data_q;
  assign busy     = !idle;

  // External bus and eviction buffer.
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    if (st_q == ST_FILL) begin
      mem_req  = 1'b1;
      mem_addr = {q_tag, q_set, beat_q};
    end else if (st_q == ST_WT) begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = q_waddr;
      mem_wdata = q_data;
      mem_be    = q_be;
    end
  end

  assign evb_push = (st_q == ST_EVICT) && !evb_full;
  assign evb_addr = {tag_vec[q_way], q_set};
  assign evb_data = rd_line;

  // R5: a bus request keeps its address until acknowledged.
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: no refill starts while a dirty victim is blocked by a full buffer.
  p_evict_blocks_fill_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_EVICT && evb_full) |=> !mem_req);

  // R4: a valid dirty victim always routes through the eviction step.
  p_dirty_victim_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && cpu_we && wb_mode && !hit && vld_vec[victim] && dty_vec[victim])
      |=> (st_q == ST_EVICT));

  // R2: write-back store hits complete without the bus.
  p_wb_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (acc && cpu_we && wb_mode && hit) |=> (!busy && !mem_req));

  // R10: busy only rises after an accepted store.
  p_busy_cause_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(busy) |-> $past(cpu_req && cpu_we));

  // R8: the write-through bus phase never alters the tag store.
  p_wt_no_alloc_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (st_q == ST_WT) |-> !tag_we);

endmodule

// File: tb/wmiss_alloc_ctrl_tb.sv
`timescale 1ns/1ps
module wmiss_alloc_ctrl_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wb_mode, cpu_req, cpu_we;
  logic [29:0]  cpu_waddr;
  logic [31:0]  cpu_wdata;
  logic [3:0]   cpu_be;
  logic         busy, rd_valid, rd_hit;
  logic [31:0]  rd_data;
  logic         mem_req, mem_we, mem_ack;
  logic [29:0]  mem_addr;
  logic [31:0]  mem_wdata, mem_rdata;
  logic [3:0]   mem_be;
  logic         evb_full, evb_push;
  logic [27:0]  evb_addr;
  logic [127:0] evb_data;

  always #2.5 clk = ~clk;

  wmiss_alloc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be), .busy(busy),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .rd_data(rd_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .evb_full(evb_full), .evb_push(evb_push),
    .evb_addr(evb_addr), .evb_data(evb_data)
  );

  int n_chk = 0, n_bad = 0;

  // Reference model of the cache contents.
  bit          m_vld [16][4];
  bit          m_dty [16][4];
  logic [23:0] m_tag [16][4];
  logic [31:0] m_dat [16][4][4];
  int          m_use [16][4];
  int          use_ctr = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [29:0] wa);
    return {wa[13:0], wa[29:12]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] old, input logic [31:0] d,
                                      input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic int find_hit(input int s, input logic [23:0] t);
    for (int w = 0; w < 4; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pick_victim(input int s);
    int v, best;
    for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return w;
    v = 0; best = m_use[s][0];
    for (int w = 1; w < 4; w++) if (m_use[s][w] < best) begin v = w; best = m_use[s][w]; end
    return v;
  endfunction

  task automatic do_read(input logic [29:0] wa);
    int s, h;
    logic [23:0] t;
    s = int'(wa[5:2]); t = wa[29:6];
    h = find_hit(s, t);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_waddr = wa;
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    chk(rd_valid == 1'b1, "R11 rd_valid", 128'(rd_valid), 128'(1));
    chk(rd_hit == (h >= 0), "R11 rd_hit", 128'(rd_hit), 128'(h >= 0));
    if (h >= 0) begin
      chk(rd_data == m_dat[s][h][wa[1:0]], "R6/R11 rd_data", 128'(rd_data),
          128'(m_dat[s][h][wa[1:0]]));
      m_use[s][h] = ++use_ctr;
    end
  endtask

  task automatic do_write(input bit wb, input logic [29:0] wa, input logic [31:0] d,
                          input logic [3:0] be, input int full_hold);
    int s, h, v, pushes, beats, writes, hold;
    bit exp_push, saw_busy;
    logic [23:0] t;
    logic [127:0] vline;
    s = int'(wa[5:2]); t = wa[29:6];
    h = find_hit(s, t);
    v = pick_victim(s);
    exp_push = wb && h < 0 && m_vld[s][v] && m_dty[s][v];
    vline = {m_dat[s][v][3], m_dat[s][v][2], m_dat[s][v][1], m_dat[s][v][0]};
    pushes = 0; beats = 0; writes = 0; saw_busy = 0; hold = full_hold;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_waddr = wa; cpu_wdata = d; cpu_be = be;
    wb_mode = wb; evb_full = (hold > 0);
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      cpu_req = 1'b0;
      mem_ack = 1'b0;
      if (hold > 0) hold--;
      evb_full = (hold > 0);
      #1;
      if (!busy) break;
      saw_busy = 1;
      if (evb_push) begin
        pushes++;
        chk(!evb_full, "R4 push while full", 128'(evb_full), 128'(0));
        chk(beats == 0, "R4 push before refill", 128'(beats), 128'(0));
        chk(evb_addr == {m_tag[s][v], 4'(s)}, "R4 evb_addr", 128'(evb_addr),
            128'({m_tag[s][v], 4'(s)}));
        chk(evb_data == vline, "R4 evb_data", evb_data, vline);
      end
      if (mem_req && !mem_we) begin
        chk(!exp_push || pushes == 1, "R4 refill before push", 128'(pushes), 128'(1));
        chk(mem_addr == {t, 4'(s), 2'(beats)}, "R5 refill address", 128'(mem_addr),
            128'({t, 4'(s), 2'(beats)}));
        if ($urandom_range(0, 2) != 0) begin
          mem_ack = 1'b1; mem_rdata = pat(mem_addr); beats++;
        end
      end else if (mem_req && mem_we) begin
        chk(mem_addr == wa && mem_wdata == d && mem_be == be, "R8/R9 write fields",
            {mem_addr, mem_wdata, mem_be}, {wa, d, be});
        if ($urandom_range(0, 2) != 0) begin
          mem_ack = 1'b1; writes++;
        end
      end
    end
    chk(!mem_req && !evb_push, "R10 quiet after busy", 128'({mem_req, evb_push}), 128'(0));
    chk(saw_busy == !(wb && h >= 0), "R2/R10 busy seen", 128'(saw_busy), 128'(!(wb && h >= 0)));
    chk(pushes == int'(exp_push), "R4 push count", 128'(pushes), 128'(exp_push));
    chk(beats == ((wb && h < 0) ? 4 : 0), "R3/R5 refill beats", 128'(beats),
        128'((wb && h < 0) ? 4 : 0));
    chk(writes == (wb ? 0 : 1), "R8/R9 write count", 128'(writes), 128'(wb ? 0 : 1));
    // Model update.
    if (h >= 0) begin
      m_dat[s][h][wa[1:0]] = mrg(m_dat[s][h][wa[1:0]], d, be);
      if (wb) m_dty[s][h] = 1;
      m_use[s][h] = ++use_ctr;
    end else if (wb) begin
      for (int k = 0; k < 4; k++) m_dat[s][v][k] = pat({t, 4'(s), 2'(k)});
      m_dat[s][v][wa[1:0]] = mrg(m_dat[s][v][wa[1:0]], d, be);
      m_tag[s][v] = t; m_vld[s][v] = 1; m_dty[s][v] = 1;
      m_use[s][v] = ++use_ctr;
    end
  endtask

  function automatic logic [29:0] mk(input logic [23:0] t, input int s, input int o);
    return {t, 4'(s), 2'(o)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = '0; m_use[s][w] = 0;
        for (int k = 0; k < 4; k++) m_dat[s][w][k] = '0;
      end
    rst_n = 1'b0; wb_mode = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_waddr = '0;
    cpu_wdata = '0; cpu_be = '0; mem_ack = 1'b0; mem_rdata = '0; evb_full = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !mem_req && !evb_push, "R1 reset outputs",
        128'({busy, mem_req, evb_push}), 128'(0));
    do_read(mk(24'h10, 2, 0));               // R1: empty cache misses
    do_read(mk(24'h00, 0, 3));

    // R3/R5/R6: fill set 2 through all four ways.
    do_write(1, mk(24'h10, 2, 1), 32'hDEAD_BEEF, 4'b1111, 0);
    do_read(mk(24'h10, 2, 1));
    do_read(mk(24'h10, 2, 0));
    do_write(1, mk(24'h11, 2, 3), 32'h1234_5678, 4'b0011, 0);
    do_write(1, mk(24'h12, 2, 0), 32'hCAFE_F00D, 4'b1000, 0);
    do_write(1, mk(24'h13, 2, 2), 32'h0BAD_C0DE, 4'b0110, 0);
    // R7: touch tag 0x10 so 0x11 becomes the oldest; R4: full buffer stalls the push.
    do_read(mk(24'h10, 2, 2));
    do_write(1, mk(24'h14, 2, 1), 32'h5555_AAAA, 4'b1111, 5);
    do_read(mk(24'h11, 2, 3));               // R3: evicted line now misses
    do_read(mk(24'h10, 2, 1));               // R7: recently used line survived
    // R9: write-through hit keeps the line and writes memory.
    do_write(0, mk(24'h12, 2, 0), 32'h7777_8888, 4'b0101, 0);
    do_read(mk(24'h12, 2, 0));
    // R8: write-through miss allocates nothing.
    do_write(0, mk(24'h20, 2, 1), 32'h9999_0000, 4'b1111, 0);
    do_read(mk(24'h20, 2, 1));
    // R2: write-back hit stays off the bus.
    do_write(1, mk(24'h13, 2, 2), 32'hF0F0_F0F0, 4'b1000, 0);
    do_read(mk(24'h13, 2, 2));

    // Constrained random mix over a few sets and tags.
    for (int n = 0; n < 600; n++) begin
      logic [29:0] wa;
      wa = mk(24'(24'h30 + $urandom_range(0, 6)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)));
      if ($urandom_range(0, 2) == 0) do_read(wa);
      else do_write($urandom_range(0, 3) != 0, wa, $urandom, 4'($urandom_range(1, 15)),
                    ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 4)) : 0);
    end

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule